// File: doc/BRIEF.md
# Self-Starting Six-State Sequence Counter

This block is a 3-bit synchronous counter that walks a fixed cycle of six codes and never uses the two codes 011 and 111 in normal counting. Each state bit is a JK-style stage. Its J and K terms come from the current state, with the unused codes treated as free choices when the terms were simplified. Those choices make the counter self-starting: if an upset leaves the register in either unused code, the next enabled clock puts it back on the legal cycle.

The counter advances only while its enable is high. An asynchronous active-low reset clears it to 000. A synchronous force port loads any 3-bit code, including the unused ones, so that recovery can be exercised on purpose. A terminal flag marks the last code of the cycle, which allows a wider divider or a sequencer to be built around it.

Top module: `sixcnt_top`

## Requirements
- R1: While rstN is low the state output is 000 and terminal is 0. The reset acts at once, without waiting for a clock edge.
- R2: With enable high and forceEn low, each rising clock edge moves the state along 000 -> 001 -> 010 -> 100 -> 101 -> 110 -> 000. The state is read as {A,B,C} = stateOut[2:0], with A the most significant bit.
- R3: With enable low and forceEn low, the state does not change across a clock edge.
- R4: With forceEn high, the next clock edge loads forceVal into the state, whatever the value of enable.
- R5: From code 011, one enabled clock edge gives 100.
- R6: From code 111, one enabled clock edge gives 000.
- R7: terminal is 1 exactly while the state is 110.
- R8: Enabled counting from any code never produces 011 or 111. These codes can only appear through the force port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low; clears the state to 000 |
| enable | input | 1 | Advance the sequence on the next edge when high |
| forceEn | input | 1 | Load forceVal on the next edge; takes priority over enable |
| forceVal | input | 3 | Code to load, {A,B,C} |
| stateOut | output | 3 | Current state {A,B,C} |
| terminal | output | 1 | High while the state is 110 |

## Verification
The block's only sizing constant is the 3-bit state width, which is fixed in the package. The bench therefore builds the block with its defaults, and with that width all eight codes can be forced directly. The bench forces both unused codes and checks the single recovery step from each. It also walks the full legal cycle more than once, interleaves hold cycles and force cycles taken with enable both high and low, and pulls the reset in the middle of a clock period to confirm that the clear takes effect at once.

// File: rtl/sixcnt_pkg.sv
`timescale 1ns/1ps
package sixcnt_pkg;
  localparam int STATE_W = 3;
  typedef logic [STATE_W-1:0] code_t;
  localparam code_t CODE_RESET = 3'b000;
  localparam code_t CODE_TERM  = 3'b110;
  // Bit positions of the named state bits inside the state vector.
  localparam int BIT_A = 2;
  localparam int BIT_B = 1;
  localparam int BIT_C = 0;

  typedef struct packed {
    logic load;  // synchronous load of the forced code
    logic step;  // advance one state along the sequence
  } strobe_t;
endpackage

// File: rtl/sixcnt_jkbit.sv
`timescale 1ns/1ps
// One state bit: a JK stage with a synchronous load and a step qualifier.
module sixcnt_jkbit (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic loadVal,
  input  logic step,
  input  logic jIn,
  input  logic kIn,
  output logic q
);
  logic jkNext;

  always_comb begin
    jkNext = (jIn & ~q) | (~kIn & q);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q <= 1'b0;
    end else if (load) begin
      q <= loadVal;
    end else if (step) begin
      q <= jkNext;
    end
  end
endmodule

// File: rtl/sixcnt_ctrl.sv
`timescale 1ns/1ps
// Control: turns the port requests into strobes. Force wins over enable.
module sixcnt_ctrl
  import sixcnt_pkg::*;
(
  input  logic    enable,
  input  logic    forceEn,
  output strobe_t strobes
);
  always_comb begin
    strobes.load = forceEn;
    strobes.step = enable & ~forceEn;
  end
endmodule

// File: rtl/sixcnt_dpath.sv
`timescale 1ns/1ps
// Datapath: three JK stages with J/K terms chosen so that both unused codes
// return to the cycle in one step (011 -> 100, 111 -> 000).
module sixcnt_dpath
  import sixcnt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobes,
  input  code_t   forceVal,
  output code_t   state
);
  code_t jVec;
  code_t kVec;

  always_comb begin
    // Bit A toggles when B is set.
    jVec[BIT_A] = state[BIT_B];
    kVec[BIT_A] = state[BIT_B];
    // Bit B is set from C and always clears after one step.
    jVec[BIT_B] = state[BIT_C];
    kVec[BIT_B] = 1'b1;
    // Bit C is set when B is clear and always clears after one step.
    jVec[BIT_C] = ~state[BIT_B];
    kVec[BIT_C] = 1'b1;
  end

  for (genvar i = 0; i < STATE_W; i++) begin : g_bit
    sixcnt_jkbit u_bit (
      .clk    (clk),
      .rstN   (rstN),
      .load   (strobes.load),
      .loadVal(forceVal[i]),
      .step   (strobes.step),
      .jIn    (jVec[i]),
      .kIn    (kVec[i]),
      .q      (state[i])
    );
  end
endmodule

// File: rtl/sixcnt_top.sv
`timescale 1ns/1ps
module sixcnt_top
  import sixcnt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         forceEn,
  input  logic [2:0]   forceVal,
  output logic [2:0]   stateOut,
  output logic         terminal
);
  strobe_t strobes;
  code_t   state;

  sixcnt_ctrl u_ctrl (
    .enable (enable),
    .forceEn(forceEn),
    .strobes(strobes)
  );

  sixcnt_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .forceVal(forceVal),
    .state   (state)
  );

  assign stateOut = state;
  assign terminal = (state == CODE_TERM);
endmodule

// File: rtl/sixcnt_chk.sv
`timescale 1ns/1ps
module sixcnt_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       forceEn,
  input logic [2:0] forceVal,
  input logic [2:0] state,
  input logic       terminal
);
  // Successor of each code, written from the required sequence.
  function automatic logic [2:0] specNext(input logic [2:0] s);
    case (s)
      3'b000:  specNext = 3'b001;
      3'b001:  specNext = 3'b010;
      3'b010:  specNext = 3'b100;
      3'b100:  specNext = 3'b101;
      3'b101:  specNext = 3'b110;
      3'b110:  specNext = 3'b000;
      3'b011:  specNext = 3'b100;
      default: specNext = 3'b000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_zero_r1: assert (state == 3'b000 && !terminal)
        else $error("reset state wrong");
    end
  end

  p_sequence_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !forceEn) |=> state == specNext($past(state)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !forceEn) |=> $stable(state));

  p_force_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    forceEn |=> state == $past(forceVal));

  p_recover_011_r5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !forceEn && state == 3'b011) |=> state == 3'b100);

  p_recover_111_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !forceEn && state == 3'b111) |=> state == 3'b000);

  p_terminal_r7: assert property (@(posedge clk) disable iff (!rstN)
    terminal == (state == 3'b110));

  p_no_unused_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !forceEn) |=> (state != 3'b011 && state != 3'b111));
endmodule

bind sixcnt_top sixcnt_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .forceEn (forceEn),
  .forceVal(forceVal),
  .state   (stateOut),
  .terminal(terminal)
);

// File: tb/sixcnt_top_tb.sv
`timescale 1ns/1ps
module sixcnt_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       forceEn = 1'b0;
  logic [2:0] forceVal = 3'b000;
  logic [2:0] stateOut;
  logic       terminal;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [2:0] model = 3'b000;
  logic [2:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  sixcnt_top u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .forceEn (forceEn),
    .forceVal(forceVal),
    .stateOut(stateOut),
    .terminal(terminal)
  );

  function automatic logic [2:0] refNext(input logic [2:0] s);
    case (s)
      3'b000:  refNext = 3'b001;
      3'b001:  refNext = 3'b010;
      3'b010:  refNext = 3'b100;
      3'b100:  refNext = 3'b101;
      3'b101:  refNext = 3'b110;
      3'b110:  refNext = 3'b000;
      3'b011:  refNext = 3'b100;
      default: refNext = 3'b000;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected state.
  task automatic drive(input logic en, input logic fe, input logic [2:0] fv,
                       input string tag);
    @(negedge clk);
    enable = en;
    forceEn = fe;
    forceVal = fv;
    if (fe) model = fv;
    else if (en) model = refNext(model);
    expQ.push_back(model);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares after each rising edge.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      logic [2:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(stateOut === e, t, stateOut, e);
      check(terminal === (e == 3'b110), "R7", terminal, (e == 3'b110));
      if (t == "R8") check(stateOut != 3'b011 && stateOut != 3'b111, "R8", stateOut, e);
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #7;
    check(stateOut === 3'b000, "R1", stateOut, 0);
    check(terminal === 1'b0, "R1", terminal, 0);
    @(negedge clk);
    rstN = 1'b1;
    model = 3'b000;

    // R2/R8: two full laps of the sequence
    for (int i = 0; i < 12; i++) drive(1'b1, 1'b0, 3'b000, "R8");
    // R3: hold with enable low
    drive(1'b1, 1'b0, 3'b000, "R2");
    drive(1'b1, 1'b0, 3'b000, "R2");
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 3'b111, "R3");
    drive(1'b1, 1'b0, 3'b000, "R2");
    drive(1'b0, 1'b0, 3'b000, "R3");
    // R4 and R5: force 011, then recover in one step
    drive(1'b0, 1'b1, 3'b011, "R4");
    drive(1'b0, 1'b0, 3'b000, "R3");
    drive(1'b1, 1'b0, 3'b000, "R5");
    // R4 and R6: force 111 with enable high, then recover
    drive(1'b1, 1'b1, 3'b111, "R4");
    drive(1'b1, 1'b0, 3'b000, "R6");
    // R4: force 110 has priority over enable; R7 terminal
    drive(1'b1, 1'b1, 3'b110, "R4");
    drive(1'b1, 1'b0, 3'b000, "R2");
    // R4: every code forced in turn, each followed by one step
    for (int v = 0; v < 8; v++) begin
      drive(1'b0, 1'b1, 3'(v), "R4");
      drive(1'b1, 1'b0, 3'b000, "R8");
    end
    // Irregular enable pattern
    for (int i = 0; i < 10; i++) drive(1'(i % 3 != 0), 1'b0, 3'b000, "R2");

    // R1: asynchronous reset in the middle of a period
    drive(1'b0, 1'b1, 3'b101, "R4");
    @(negedge clk);
    forceEn = 1'b0;
    #1;
    rstN = 1'b0;
    #0.5;
    check(stateOut === 3'b000, "R1", stateOut, 0);
    check(terminal === 1'b0, "R1", terminal, 0);
    @(negedge clk);
    rstN = 1'b1;
    model = 3'b000;
    for (int i = 0; i < 6; i++) drive(1'b1, 1'b0, 3'b000, "R2");

    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule